// File: doc/BRIEF.md
# Leveled Interrupt Priority Arbiter

This block decides which interrupt the CPU takes next. It watches fifteen latched, maskable interrupt factor flags and one non-maskable watchdog flag. Each factor flag is gated by its own enable bit. The maskable factors fall into five fixed groups: timers, key inputs, serial port, stopwatch and clock timer. Each group has a two-bit priority register that sets its level from 0 to 3. The watchdog request sits at level 4, above all of them.

Every cycle the block compares the pending levels with the CPU's two-bit interrupt mask. It registers the winning request together with its level and a fixed vector address. When the CPU acknowledges, the block emits a one-cycle accept pulse. In that cycle it presents the accepted level, the vector and the mask value the CPU must load.

Requests follow the factor flags as levels, not edges. A handler that lowers the mask before clearing its factor flag is therefore interrupted again by the same source.

Top module: `irq_level_arbiter`

## Requirements
- R1: After reset all five group priority registers read as level 0, `irq_req` and `acc_pulse` are low, and no maskable factor is requested until its group is given a non-zero level.
- R2: A maskable request at level L (1..3) is presented only when L is greater than the mask value `cpu_mask` = {I1,I0}. Mask 3 admits no maskable level, mask 2 admits level 3, mask 1 admits levels 2..3 and mask 0 admits levels 1..3.
- R3: A set `nmi_flag` is presented at level 4 with vector 0x000004 whatever the mask holds, and it wins over every maskable request.
- R4: A factor whose group is at level 0 is never presented.
- R5: Among eligible requests the highest level wins. Among requests at that level, the one with the lowest vector address wins.
- R6: Factor i (bit i of `factor_flags`, 0..14) has vector 2*(3+i). In bit order the factors are: timer 1, timer 0, key K10, keys K04..K07, keys K00..K03, serial error, receive done, transmit done, stopwatch 100 Hz, 10 Hz and 1 Hz, and clock 32 Hz, 8 Hz, 2 Hz and 1 Hz. This places them from 0x000006 up to 0x000022.
- R7: A factor whose bit in `factor_en` is 0 takes no part in arbitration.
- R8: `irq_req`, `irq_level` and `irq_vector` are registered one cycle after their inputs. Sampling `cpu_ack`=1 while `irq_req`=1 raises `acc_pulse` for exactly one cycle on the next cycle, carrying the request that was presented. No pulse follows directly after a pulse. `cpu_ack` without a request does nothing.
- R9: `acc_mask` equals the accepted level for a maskable interrupt and equals 3 for the watchdog interrupt.
- R10: Requests are level-sensitive. A factor that is still flagged but held off by the mask is presented again once the mask is lowered below its level.
- R11: A write with `prio_we`=1 stores `prio_wdata` into the group selected by `prio_sel`: 0 timers (bits 0..1), 1 keys (bits 2..4), 2 serial (bits 5..7), 3 stopwatch (bits 8..10), 4 clock (bits 11..14). Group membership is fixed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prio_we | input | 1 | Priority register write strobe |
| prio_sel | input | 3 | Group index to write |
| prio_wdata | input | 2 | New group level |
| factor_flags | input | 15 | Latched maskable interrupt factor flags |
| factor_en | input | 15 | Per-factor enable bits |
| nmi_flag | input | 1 | Watchdog non-maskable request |
| cpu_mask | input | 2 | CPU interrupt mask {I1,I0} |
| cpu_ack | input | 1 | CPU acknowledge of the presented request |
| irq_req | output | 1 | A request is presented |
| irq_level | output | 3 | Level of the presented request |
| irq_vector | output | 24 | Vector address of the presented request |
| acc_pulse | output | 1 | One-cycle accept strobe |
| acc_level | output | 3 | Accepted level, valid with acc_pulse |
| acc_vector | output | 24 | Accepted vector, valid with acc_pulse |
| acc_mask | output | 2 | Mask value for the CPU to load, valid with acc_pulse |

## Verification
Acknowledgement and re-arbitration can fall in the same cycle. A higher-level factor can become pending on the very edge at which the CPU's acknowledge of a lower request is sampled. The bench raises a level-3 flag together with `cpu_ack` while a level-1 request is presented. It then expects the accept pulse to carry the level-1 vector and mask, while `irq_vector` already moves to the level-3 source in the same cycle.

// File: rtl/irqarb_pkg.sv
package irqarb_pkg;

    localparam int NUM_FACTORS = 15;
    localparam int NUM_GROUPS  = 5;
    localparam int GROUP_W     = $clog2(NUM_GROUPS);
    localparam int LVL_W       = 3;
    localparam int ADDR_W      = 24;
    localparam int FIRST_SLOT  = 3;
    localparam int NMI_SLOT    = 2;
    localparam logic [LVL_W-1:0] NMI_LEVEL = 3'd4;
    localparam logic [1:0]       NMI_MASK  = 2'd3;

    typedef logic [1:0] prio_t;

    typedef struct packed {
        logic              valid;
        logic [LVL_W-1:0]  level;
        logic [ADDR_W-1:0] vector;
    } win_t;

    // fixed factor-to-group membership
    function automatic int group_of(input int f);
        if (f < 2)       return 0;
        else if (f < 5)  return 1;
        else if (f < 8)  return 2;
        else if (f < 11) return 3;
        else             return 4;
    endfunction

    function automatic logic [ADDR_W-1:0] vector_of(input int slot);
        return ADDR_W'(2 * slot);
    endfunction

    function automatic logic admits(input logic [LVL_W-1:0] lvl, input logic [1:0] mask);
        return lvl > {1'b0, mask};
    endfunction

    function automatic logic [1:0] mask_after(input logic [LVL_W-1:0] lvl);
        return (lvl == NMI_LEVEL) ? NMI_MASK : lvl[1:0];
    endfunction

endpackage

// File: rtl/irqarb_prio_regs.sv
module irqarb_prio_regs
    import irqarb_pkg::*;
#(
    parameter int N_GRP = NUM_GROUPS,
    parameter int SEL_W = GROUP_W
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         we,
    input  logic [SEL_W-1:0]             sel,
    input  prio_t                        wdata,
    output logic [N_GRP-1:0][1:0]        prio_q
);

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        localparam logic [SEL_W-1:0] IDX = SEL_W'(g);
        always_ff @(posedge clk) begin
            if (rst)
                prio_q[g] <= 2'd0;
            else if (we && sel == IDX)
                prio_q[g] <= wdata;
        end
    end

    p_prio_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> prio_q == '0);

    p_prio_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (!$past(we) && !$past(rst)) |-> $stable(prio_q));

endmodule

// File: rtl/irqarb_select.sv
module irqarb_select
    import irqarb_pkg::*;
#(
    parameter int N_FAC = NUM_FACTORS,
    parameter int N_GRP = NUM_GROUPS
) (
    input  logic [N_FAC-1:0]      flags,
    input  logic [N_FAC-1:0]      enables,
    input  logic                  nmi,
    input  logic [1:0]            mask,
    input  logic [N_GRP-1:0][1:0] prio,
    output win_t                  win
);

    logic [LVL_W-1:0]  lvl_f [N_FAC];
    logic [ADDR_W-1:0] vec_f [N_FAC];
    logic [N_FAC-1:0]  elig;

    for (genvar i = 0; i < N_FAC; i++) begin : g_fac
        localparam int G = group_of(i);
        localparam logic [ADDR_W-1:0] VEC = vector_of(FIRST_SLOT + i);
        assign lvl_f[i] = {1'b0, prio[G]};
        assign vec_f[i] = VEC;
        // level 0 never passes admits(), so it acts as disabled
        assign elig[i]  = flags[i] && enables[i] && admits(lvl_f[i], mask);
    end

    always_comb begin
        win = '0;
        // walk from the top slot downwards; >= lets the lower vector take ties
        for (int i = N_FAC - 1; i >= 0; i--) begin
            if (elig[i] && (!win.valid || lvl_f[i] >= win.level)) begin
                win.valid  = 1'b1;
                win.level  = lvl_f[i];
                win.vector = vec_f[i];
            end
        end
        if (nmi) begin
            win.valid  = 1'b1;
            win.level  = NMI_LEVEL;
            win.vector = vector_of(NMI_SLOT);
        end
    end

endmodule

// File: rtl/irqarb_accept.sv
module irqarb_accept
    import irqarb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  win_t              req,
    input  logic              ack,
    output logic              pulse,
    output logic [LVL_W-1:0]  level,
    output logic [ADDR_W-1:0] vector,
    output logic [1:0]        mask
);

    logic take;
    assign take = ack && req.valid && !pulse;

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse  <= 1'b0;
            level  <= '0;
            vector <= '0;
            mask   <= '0;
        end else begin
            pulse <= take;
            if (take) begin
                level  <= req.level;
                vector <= req.vector;
                mask   <= mask_after(req.level);
            end
        end
    end

    p_ack_qualified_r8: assert property (@(posedge clk) disable iff (rst)
        pulse |-> ($past(ack) && $past(req.valid)));

    p_single_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);

    p_carries_request_r8: assert property (@(posedge clk) disable iff (rst)
        pulse |-> (level == $past(req.level) && vector == $past(req.vector)));

    p_nmi_mask_r9: assert property (@(posedge clk) disable iff (rst)
        (pulse && level == NMI_LEVEL) |-> mask == 2'd3);

    p_maskable_mask_r9: assert property (@(posedge clk) disable iff (rst)
        (pulse && level != NMI_LEVEL) |-> {1'b0, mask} == level);

endmodule

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter
    import irqarb_pkg::*;
#(
    parameter int N_FAC = NUM_FACTORS,
    parameter int N_GRP = NUM_GROUPS,
    parameter int SEL_W = GROUP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prio_we,
    input  logic [SEL_W-1:0]  prio_sel,
    input  logic [1:0]        prio_wdata,
    input  logic [N_FAC-1:0]  factor_flags,
    input  logic [N_FAC-1:0]  factor_en,
    input  logic              nmi_flag,
    input  logic [1:0]        cpu_mask,
    input  logic              cpu_ack,
    output logic              irq_req,
    output logic [LVL_W-1:0]  irq_level,
    output logic [ADDR_W-1:0] irq_vector,
    output logic              acc_pulse,
    output logic [LVL_W-1:0]  acc_level,
    output logic [ADDR_W-1:0] acc_vector,
    output logic [1:0]        acc_mask
);

    logic [N_GRP-1:0][1:0] prio;
    win_t                  win_d;
    win_t                  win_q;

    irqarb_prio_regs #(.N_GRP(N_GRP), .SEL_W(SEL_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (prio_we),
        .sel    (prio_sel),
        .wdata  (prio_wdata),
        .prio_q (prio)
    );

    irqarb_select #(.N_FAC(N_FAC), .N_GRP(N_GRP)) u_sel (
        .flags   (factor_flags),
        .enables (factor_en),
        .nmi     (nmi_flag),
        .mask    (cpu_mask),
        .prio    (prio),
        .win     (win_d)
    );

    always_ff @(posedge clk) begin
        if (rst) win_q <= '0;
        else     win_q <= win_d;
    end

    assign irq_req    = win_q.valid;
    assign irq_level  = win_q.level;
    assign irq_vector = win_q.vector;

    irqarb_accept u_acc (
        .clk    (clk),
        .rst    (rst),
        .req    (win_q),
        .ack    (cpu_ack),
        .pulse  (acc_pulse),
        .level  (acc_level),
        .vector (acc_vector),
        .mask   (acc_mask)
    );

    p_above_mask_r2: assert property (@(posedge clk) disable iff (rst)
        (irq_req && irq_level != NMI_LEVEL) |-> irq_level > {1'b0, $past(cpu_mask)});

    p_nmi_always_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(nmi_flag)) |->
            (irq_req && irq_level == NMI_LEVEL && irq_vector == ADDR_W'(4)));

    p_no_level0_r4: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> irq_level != '0);

    p_enabled_source_r7: assert property (@(posedge clk) disable iff (rst)
        (irq_req && irq_level != NMI_LEVEL) |-> ($past(factor_flags & factor_en) != '0));

endmodule

// File: tb/irq_level_arbiter_test.sv
module irq_level_arbiter_test;
    import irqarb_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              prio_we = 1'b0;
    logic [2:0]        prio_sel = '0;
    logic [1:0]        prio_wdata = '0;
    logic [14:0]       factor_flags = '0;
    logic [14:0]       factor_en = '0;
    logic              nmi_flag = 1'b0;
    logic [1:0]        cpu_mask = '0;
    logic              cpu_ack = 1'b0;
    logic              irq_req;
    logic [2:0]        irq_level;
    logic [23:0]       irq_vector;
    logic              acc_pulse;
    logic [2:0]        acc_level;
    logic [23:0]       acc_vector;
    logic [1:0]        acc_mask;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    irq_level_arbiter uut (
        .clk(clk), .rst(rst), .prio_we(prio_we), .prio_sel(prio_sel),
        .prio_wdata(prio_wdata), .factor_flags(factor_flags), .factor_en(factor_en),
        .nmi_flag(nmi_flag), .cpu_mask(cpu_mask), .cpu_ack(cpu_ack),
        .irq_req(irq_req), .irq_level(irq_level), .irq_vector(irq_vector),
        .acc_pulse(acc_pulse), .acc_level(acc_level), .acc_vector(acc_vector),
        .acc_mask(acc_mask)
    );

    // {flags15, en15, mask2, nmi1, exp_req1, exp_level3, exp_vec8}
    // group levels: timers 1, keys 2, serial 3, stopwatch 0, clock 2
    localparam int NV = 16;
    localparam logic [44:0] VECS [NV] = '{
        {15'h0000, 15'h7FFF, 2'd0, 1'b0, 1'b0, 3'd0, 8'h00}, // R1 idle
        {15'h0001, 15'h7FFF, 2'd0, 1'b0, 1'b1, 3'd1, 8'h06}, // R2 L1 mask0
        {15'h0001, 15'h7FFF, 2'd1, 1'b0, 1'b0, 3'd0, 8'h00}, // R2 L1 mask1
        {15'h0004, 15'h7FFF, 2'd1, 1'b0, 1'b1, 3'd2, 8'h0A}, // R2 L2 mask1
        {15'h0004, 15'h7FFF, 2'd2, 1'b0, 1'b0, 3'd0, 8'h00}, // R2 L2 mask2
        {15'h0020, 15'h7FFF, 2'd2, 1'b0, 1'b1, 3'd3, 8'h10}, // R2 L3 mask2
        {15'h0020, 15'h7FFF, 2'd3, 1'b0, 1'b0, 3'd0, 8'h00}, // R2 L3 mask3
        {15'h0020, 15'h7FFF, 2'd3, 1'b1, 1'b1, 3'd4, 8'h04}, // R3 nmi mask3
        {15'h0100, 15'h7FFF, 2'd0, 1'b0, 1'b0, 3'd0, 8'h00}, // R4 level 0
        {15'h1002, 15'h7FFF, 2'd0, 1'b0, 1'b1, 3'd2, 8'h1E}, // R5 higher level
        {15'h6800, 15'h7FFF, 2'd0, 1'b0, 1'b1, 3'd2, 8'h1C}, // R5 tie in group
        {15'h2008, 15'h7FFF, 2'd0, 1'b0, 1'b1, 3'd2, 8'h0C}, // R5 tie across groups
        {15'h0090, 15'h7F7F, 2'd0, 1'b0, 1'b1, 3'd2, 8'h0E}, // R7 disabled L3
        {15'h7FFF, 15'h7FFF, 2'd0, 1'b0, 1'b1, 3'd3, 8'h10}, // R5 all pending
        {15'h4000, 15'h7FFF, 2'd1, 1'b0, 1'b1, 3'd2, 8'h22}, // R6 last slot
        {15'h0040, 15'h7FFF, 2'd0, 1'b0, 1'b1, 3'd3, 8'h12}  // R6 receive done
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_prio(input logic [2:0] grp, input logic [1:0] lvl);
        prio_we = 1'b1; prio_sel = grp; prio_wdata = lvl;
        @(negedge clk);
        prio_we = 1'b0;
    endtask

    task automatic set_default_levels();
        wr_prio(3'd0, 2'd1);
        wr_prio(3'd1, 2'd2);
        wr_prio(3'd2, 2'd3);
        wr_prio(3'd3, 2'd0);
        wr_prio(3'd4, 2'd2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        factor_en = 15'h7FFF;
        repeat (3) @(negedge clk);
        chk("R1 req in reset", 32'(irq_req), 0);
        rst = 1'b0;
        factor_flags = 15'h0001;
        @(negedge clk);
        @(negedge clk);
        chk("R1 no request with levels 0", 32'(irq_req), 0);
        chk("R1 no pulse after reset", 32'(acc_pulse), 0);

        set_default_levels();
        for (int k = 0; k < NV; k++) begin
            logic [44:0] e;
            e = VECS[k];
            factor_flags = e[44:30];
            factor_en    = e[29:15];
            cpu_mask     = e[14:13];
            nmi_flag     = e[12];
            @(negedge clk);
            chk($sformatf("R2/R3/R4/R5/R6/R7 vec%0d req", k), 32'(irq_req), 32'(e[11]));
            if (e[11]) begin
                chk($sformatf("R5 vec%0d level", k), 32'(irq_level), 32'(e[10:8]));
                chk($sformatf("R6 vec%0d vector", k), 32'(irq_vector), {24'h0, e[7:0]});
            end
        end
        nmi_flag = 1'b0;
        factor_en = 15'h7FFF;

        // R8/R9 level-3 accept, ack held two cycles
        factor_flags = 15'h0020; cpu_mask = 2'd0;
        @(negedge clk);
        cpu_ack = 1'b1;
        @(negedge clk);
        chk("R8 pulse on ack", 32'(acc_pulse), 1);
        chk("R8 accepted vector", 32'(acc_vector), 32'h10);
        chk("R8 accepted level", 32'(acc_level), 3);
        chk("R9 mask after level 3", 32'(acc_mask), 3);
        @(negedge clk);
        chk("R8 no back-to-back pulse", 32'(acc_pulse), 0);
        cpu_ack = 1'b0;
        @(negedge clk);

        // R9 watchdog accept under mask 0
        nmi_flag = 1'b1;
        @(negedge clk);
        cpu_ack = 1'b1;
        @(negedge clk);
        cpu_ack = 1'b0;
        chk("R3 nmi beats level 3", 32'(acc_level), 4);
        chk("R3 nmi vector", 32'(acc_vector), 32'h04);
        chk("R9 mask after nmi", 32'(acc_mask), 3);
        nmi_flag = 1'b0;
        @(negedge clk);

        // R9 level-2 accept
        factor_flags = 15'h0004;
        @(negedge clk);
        cpu_ack = 1'b1;
        @(negedge clk);
        cpu_ack = 1'b0;
        chk("R9 mask after level 2", 32'(acc_mask), 2);
        chk("R8 pulse level 2", 32'(acc_pulse), 1);

        // R10 mask lowered while flag still set
        cpu_mask = 2'd2;
        @(negedge clk);
        chk("R10 held off by mask", 32'(irq_req), 0);
        cpu_mask = 2'd1;
        @(negedge clk);
        chk("R10 raised again", 32'(irq_req), 1);
        chk("R10 same vector", 32'(irq_vector), 32'h0A);

        // R8 ack with nothing pending
        factor_flags = 15'h0000; cpu_mask = 2'd0;
        @(negedge clk);
        cpu_ack = 1'b1;
        @(negedge clk);
        cpu_ack = 1'b0;
        chk("R8 ack without request", 32'(acc_pulse), 0);

        // same cycle: ack of level 1 while level 3 arrives
        factor_flags = 15'h0001;
        @(negedge clk);
        factor_flags = 15'h0021;
        cpu_ack = 1'b1;
        @(negedge clk);
        cpu_ack = 1'b0;
        chk("R8 pulse keeps presented request", 32'(acc_vector), 32'h06);
        chk("R9 mask for level 1", 32'(acc_mask), 1);
        chk("R5 request moves to level 3", 32'(irq_vector), 32'h10);

        // R11 group write reaches only its members
        factor_flags = 15'h0200;
        @(negedge clk);
        chk("R11 stopwatch still level 0", 32'(irq_req), 0);
        wr_prio(3'd3, 2'd3);
        @(negedge clk);
        chk("R11 stopwatch 10Hz at level 3", 32'(irq_level), 3);
        chk("R11 stopwatch vector", 32'(irq_vector), 32'h18);
        factor_flags = 15'h0800;
        @(negedge clk);
        chk("R11 clock group kept level 2", 32'(irq_level), 2);

        // R1 reset mid-run clears levels
        factor_flags = 15'h0020;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 levels cleared by reset", 32'(irq_req), 0);
        chk("R1 pulse low after reset", 32'(acc_pulse), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule